// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Resolver

This block is the arithmetic stage of a small in-order processor. A combinational datapath forms one of four operations on two operands. The operand called B is the destination operand, so every operation computes B op A. An immediate-add instruction reaches the same adder by presenting its immediate on A, and it sets the flags exactly as a register add does.

Three condition flags are derived from each result: zero, sign and overflow. They are captured into a flag register on a clock edge when the caller asks for it. A branch resolver reads the registered flags and reports whether a conditional transfer selected by a 4-bit condition code is taken.

Register access, decoding and memory belong to neighbouring blocks.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 (add) drives `alu_result` with B + A modulo 2^32, combinationally.
- R2: Function code 1 (subtract) drives `alu_result` with B − A modulo 2^32, combinationally.
- R3: Function code 2 drives B AND A and function code 3 drives B XOR A.
- R4: The next zero flag is 1 exactly when `alu_result` is all zeros. The next sign flag equals bit 31 of `alu_result`.
- R5: For add, overflow is 1 when A and B share a sign and the result's sign differs from it.
- R6: For subtract, overflow is 1 when (A > 0 as a signed value) equals (B < 0) and the result's sign differs from B's sign.
- R7: For AND, XOR and every unused function code (4 to 15), overflow is 0. An unused function code drives a result of zero.
- R8: `cc_flags` packs zero in bit 2, sign in bit 1 and overflow in bit 0. When `flag_we` is 1 at a rising edge, it takes the flags of the current operation after that edge.
- R9: When `flag_we` is 0 at a rising edge, `cc_flags` keeps its value.
- R10: A synchronous active-high `rst` sets `cc_flags` to 3'b100 (Z=1, S=0, O=0).
- R11: `br_taken` is computed from `cc_flags` using `br_cond` as follows:
  - 0: always taken.
  - 1: (S^O)|Z.
  - 2: S^O.
  - 3: Z.
  - 4: !Z.
  - 5: !(S^O).
  - 6: !(S^O)&!Z.
- R12: `br_cond` values 7 to 15 give `br_taken` = 0 for every flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_fn | input | 4 | Operation select |
| op_a | input | 32 | Operand A (source) |
| op_b | input | 32 | Operand B (destination) |
| flag_we | input | 1 | Capture flags at the next edge |
| br_cond | input | 4 | Branch condition select |
| alu_result | output | 32 | Result of B op A |
| cc_flags | output | 3 | Registered flags {Z,S,O} |
| br_taken | output | 1 | Branch decision from registered flags |

## Verification
The bench builds the block with its default 32-bit data width, so the sign bit is bit 31. Operands such as 0x7FFFFFFF and 0x80000000 are therefore enough to reach every overflow corner of add and subtract, including subtracting the most negative value and subtracting from zero. The operation sequence drives the flag register through six distinct flag patterns. In each pattern all sixteen branch codes are evaluated, which covers every condition at both outcomes wherever that outcome is reachable.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int DATA_W = 32;
    localparam int FN_W   = 4;
    localparam int COND_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_op_e;

    typedef enum logic [COND_W-1:0] {
        BR_ALWAYS = 4'd0,
        BR_LE     = 4'd1,
        BR_LT     = 4'd2,
        BR_EQ     = 4'd3,
        BR_NE     = 4'd4,
        BR_GE     = 4'd5,
        BR_GT     = 4'd6
    } br_cond_e;

    // Packed order matters: zero is the MSB, overflow the LSB.
    typedef struct packed {
        logic z;
        logic s;
        logic o;
    } cc_t;

    localparam cc_t CC_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};

    function automatic logic add_ovf(input logic a_neg, input logic b_neg,
                                     input logic r_neg);
        return (a_neg == b_neg) && (r_neg != b_neg);
    endfunction

    // Destination minus source; a_pos means strictly positive.
    function automatic logic sub_ovf(input logic a_pos, input logic b_neg,
                                     input logic r_neg);
        return (a_pos == b_neg) && (r_neg != b_neg);
    endfunction

    function automatic logic cond_eval(input br_cond_e c, input cc_t f);
        logic lt;
        lt = f.s ^ f.o;
        case (c)
            BR_ALWAYS: return 1'b1;
            BR_LE:     return lt | f.z;
            BR_LT:     return lt;
            BR_EQ:     return f.z;
            BR_NE:     return ~f.z;
            BR_GE:     return ~lt;
            BR_GT:     return ~lt & ~f.z;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output cc_t          nxt
);
    localparam int MSB = W - 1;

    logic a_pos;

    always_comb begin
        a_pos = ~a[MSB] & (|a);
        res   = '0;
        nxt.o = 1'b0;
        case (op)
            FN_ADD: begin
                res   = b + a;
                nxt.o = add_ovf(a[MSB], b[MSB], res[MSB]);
            end
            FN_SUB: begin
                res   = b - a;
                nxt.o = sub_ovf(a_pos, b[MSB], res[MSB]);
            end
            FN_AND: res = b & a;
            FN_XOR: res = b ^ a;
            default: res = '0;
        endcase
        nxt.z = (res == '0);
        nxt.s = res[MSB];
    end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import alu_cc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cc_t  d,
    output cc_t  q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= CC_RESET;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_cc_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  cc_t               flags,
    output logic              taken
);
    always_comb taken = cond_eval(br_cond_e'(cond), flags);
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FN_W-1:0]   alu_fn,
    input  logic [DW-1:0]     op_a,
    input  logic [DW-1:0]     op_b,
    input  logic              flag_we,
    input  logic [COND_W-1:0] br_cond,
    output logic [DW-1:0]     alu_result,
    output logic [2:0]        cc_flags,
    output logic              br_taken
);
    cc_t nxt_cc;
    cc_t cur_cc;

    alu_core #(.W(DW)) u_core (
        .op  (alu_op_e'(alu_fn)),
        .a   (op_a),
        .b   (op_b),
        .res (alu_result),
        .nxt (nxt_cc)
    );

    cc_reg u_cc (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (nxt_cc),
        .q   (cur_cc)
    );

    branch_eval u_br (
        .cond  (br_cond),
        .flags (cur_cc),
        .taken (br_taken)
    );

    assign cc_flags = cur_cc;

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> cc_flags == $past(nxt_cc));                 // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(cc_flags));                         // R9
    AST_RESET_VAL: assert property (@(posedge clk)
        rst |=> cc_flags == 3'b100);                             // R10
    AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
        nxt_cc.z == (alu_result == '0) && nxt_cc.s == alu_result[DW-1]); // R4
    AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (alu_fn == 4'd2 || alu_fn == 4'd3 || alu_fn > 4'd3) |-> !nxt_cc.o); // R7
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        br_cond == 4'd0 |-> br_taken);                           // R11
    AST_UNUSED_COND: assert property (@(posedge clk) disable iff (rst)
        br_cond > 4'd6 |-> !br_taken);                           // R12
endmodule

// File: tb/alu_cc_unit_tb.sv
module alu_cc_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  alu_fn;
    logic [31:0] op_a, op_b;
    logic        flag_we;
    logic [3:0]  br_cond;
    logic [31:0] alu_result;
    logic [2:0]  cc_flags;
    logic        br_taken;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu_cc_unit u_dut (
        .clk(clk), .rst(rst), .alu_fn(alu_fn), .op_a(op_a), .op_b(op_b),
        .flag_we(flag_we), .br_cond(br_cond), .alu_result(alu_result),
        .cc_flags(cc_flags), .br_taken(br_taken)
    );

    typedef struct {
        logic [31:0] res;
        logic [2:0]  flg;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;
    logic [2:0] model_flg;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Independent reference: wide signed arithmetic for overflow.
    task automatic drive_op(input logic [3:0] fn, input logic [31:0] a,
                            input logic [31:0] b, input logic we,
                            input string req);
        longint sa, sb, wide;
        logic [31:0] r;
        logic o;
        exp_t it;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        o = 1'b0;
        case (fn)
            4'd0: begin wide = sb + sa; r = b + a; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            4'd1: begin wide = sb - sa; r = b - a; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            4'd2: r = a & b;
            4'd3: r = a ^ b;
            default: r = 32'h0;
        endcase
        if (we) model_flg = {r == 32'h0, r[31], o};
        it.res = r; it.flg = model_flg; it.req = req;
        @(negedge clk);
        alu_fn = fn; op_a = a; op_b = b; flag_we = we;
        sb_q.push_back(it);
        @(posedge clk); #1;
        -> mon_ev;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    initial begin
        exp_t it;
        forever begin
            @(mon_ev);
            it = sb_q.pop_front();
            check(alu_result === it.res, it.req, "result", alu_result, it.res);
            check(cc_flags === it.flg, it.req, "flags", {29'd0, cc_flags}, {29'd0, it.flg});
        end
    end

    function automatic logic ref_branch(input int c, input logic [2:0] f);
        logic z, s, o;
        z = f[2]; s = f[1]; o = f[0];
        if (c == 0) return 1'b1;
        if (c == 1) return (s != o) || z;
        if (c == 2) return s != o;
        if (c == 3) return z;
        if (c == 4) return !z;
        if (c == 5) return s == o;
        if (c == 6) return (s == o) && !z;
        return 1'b0;
    endfunction

    task automatic sweep_branches();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            br_cond = c[3:0];
            #1;
            check(br_taken === ref_branch(c, model_flg), (c > 6) ? "R12" : "R11",
                  $sformatf("cond %0d", c), {31'd0, br_taken},
                  {31'd0, ref_branch(c, model_flg)});
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; alu_fn = 4'd0; op_a = 0; op_b = 0; flag_we = 1'b1; br_cond = 4'd0;
        model_flg = 3'b100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cc_flags === 3'b100, "R10", "reset flags", {29'd0, cc_flags}, 32'd4);
        rst = 1'b0; flag_we = 1'b0;
        sweep_branches();

        drive_op(4'd0, 32'd5, 32'd3, 1'b1, "R1");
        sweep_branches();
        drive_op(4'd0, 32'd1, 32'h7FFFFFFF, 1'b1, "R5");
        sweep_branches();
        drive_op(4'd0, 32'h80000000, 32'h80000000, 1'b1, "R5");
        sweep_branches();
        drive_op(4'd0, 32'hFFFFFFFF, 32'h00000001, 1'b1, "R4");
        drive_op(4'd1, 32'd3, 32'd10, 1'b1, "R2");
        drive_op(4'd1, 32'd10, 32'd3, 1'b1, "R2");
        sweep_branches();
        drive_op(4'd1, 32'd1, 32'h80000000, 1'b1, "R6");
        sweep_branches();
        drive_op(4'd1, 32'h80000000, 32'd0, 1'b1, "R6");
        drive_op(4'd1, 32'd0, 32'h80000000, 1'b1, "R6");
        drive_op(4'd1, 32'd5, 32'd5, 1'b1, "R4");
        sweep_branches();
        drive_op(4'd2, 32'hF0F0F0F0, 32'h8F0F00FF, 1'b1, "R3");
        drive_op(4'd2, 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1, "R3");
        drive_op(4'd3, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1, "R3");
        drive_op(4'd0, 32'h80000000, 32'h80000000, 1'b1, "R8");
        drive_op(4'd3, 32'h12345678, 32'h12345678, 1'b1, "R7");
        drive_op(4'd0, 32'h80000000, 32'h80000000, 1'b1, "R8");
        drive_op(4'd2, 32'h80000001, 32'h80000003, 1'b1, "R7");
        drive_op(4'd7, 32'h7FFFFFFF, 32'h00000001, 1'b1, "R7");
        drive_op(4'd15, 32'h80000000, 32'h80000000, 1'b1, "R7");
        drive_op(4'd1, 32'd1, 32'd0, 1'b0, "R9");
        drive_op(4'd0, 32'h7FFFFFFF, 32'd1, 1'b0, "R9");
        sweep_branches();
        drive_op(4'd1, 32'd1, 32'd0, 1'b1, "R8");
        drive_op(4'd0, 32'd0, 32'd0, 1'b1, "R8");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_flg = 3'b100;
        check(cc_flags === 3'b100, "R10", "flags after mid-run reset", {29'd0, cc_flags}, 32'd4);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule